// File: doc/BRIEF.md
# Return-Address Stack Sharing the ROM Data Counter

This block saves program-counter return addresses for a small controller. It is a four-deep stack of 11-bit entries, written on a subroutine call or interrupt entry and read back on return. The controller also has an 11-bit pointer into ROM that walks fixed data tables. To save area, the deepest stack level is that same pointer register. The lower three levels are private registers.

Nesting four levels deep therefore replaces the table pointer with a return address. Loading the pointer while four levels are in use replaces the saved return address. Software sets the pointer one field at a time: low nibble, middle nibble or top three bits. It can also step the pointer by one, and it wraps at 2^11. A range flag shows whether the pointer lies inside the fitted ROM size. On the smallest configuration, any pointer with bit 10 set is outside it.

Top module: `retstack_dc`

## Requirements
- R1: After reset, depth_o is 0, dc_o is 0, top_o is 0 and underflow_o is 0.
- R2: A push at depth below 4 stores push_addr_i at level depth_o and raises depth_o by one. From the next cycle, top_o shows the pushed address.
- R3: A pop at nonzero depth (with push_i low) lowers depth_o by one. top_o then shows the entry below, so entries return last-in first-out, and depth 0 shows top_o = 0.
- R4: A push at depth 3 writes push_addr_i into the data counter, so dc_o equals the pushed address on the next cycle.
- R5: A data-counter load or increment at depth 4 changes the saved level-3 return address, and top_o shows the new dc_o value.
- R6: When dc_ld_i is high, dc_fld_i selects which field is loaded and the other bits are kept. Code 0 writes bits [3:0] from dc_ld_data_i[3:0]. Code 1 writes bits [7:4] from dc_ld_data_i[3:0]. Code 2 writes bits [10:8] from dc_ld_data_i[2:0]. Code 3 changes nothing.
- R7: dc_inc_i adds 1 to the data counter modulo 2048. The increment is ignored in any cycle where push_i or pop_i is high, and a load in the same cycle takes precedence over it.
- R8: A pop at depth 0 (with push_i low) leaves all state unchanged. underflow_o is then high for exactly the following cycle.
- R9: When push_i and pop_i are both high, only the push acts. A push at depth 4 changes nothing.
- R10: dc_in_range_o is high exactly when dc_o is below ROM_WORDS (default 1024, so it is low whenever dc_o bit 10 is set).
- R11: When a push at depth 3 and a data-counter load fall in the same cycle, the pushed address wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save a return address |
| push_addr_i | input | 11 | Return address to save |
| pop_i | input | 1 | Discard the top entry (return) |
| dc_ld_i | input | 1 | Load one data-counter field |
| dc_fld_i | input | 2 | Field select: 0 low, 1 middle, 2 high, 3 none |
| dc_ld_data_i | input | 4 | Field value to load |
| dc_inc_i | input | 1 | Step the data counter by one |
| dc_o | output | 11 | Data counter (also level 3 of the stack) |
| top_o | output | 11 | Entry at the top of the stack, 0 when empty |
| depth_o | output | 3 | Number of occupied levels, 0 to 4 |
| underflow_o | output | 1 | One-cycle flag after a pop on an empty stack |
| dc_in_range_o | output | 1 | Data counter addresses fitted ROM |

## Verification
Every result is due one clock edge after the request. This covers depth, entries, the data counter and the underflow pulse; top_o and dc_in_range_o follow combinationally from those registers. The driver applies each request on a falling edge and queues the predicted state. The monitor pops that prediction a quarter period after the next rising edge, once every register on the path has settled. The underflow pulse, the load over increment precedence and the push into the shared level are each compared in the cycle that follows them and again in the cycle after.

// File: rtl/retstack_dc_pkg.sv
package retstack_dc_pkg;
  localparam int unsigned ADDR_W_DEF    = 11;
  localparam int unsigned LEVELS_DEF    = 4;
  localparam int unsigned LO_W_DEF      = 4;
  localparam int unsigned MID_W_DEF     = 4;
  localparam int unsigned FLD_W_DEF     = 4;
  localparam int unsigned ROM_WORDS_DEF = 1024;

  typedef enum logic [1:0] {
    FLD_LO   = 2'd0,
    FLD_MID  = 2'd1,
    FLD_HI   = 2'd2,
    FLD_NONE = 2'd3
  } dc_fld_e;
endpackage

// File: rtl/retstack_dc_depth.sv
module retstack_dc_depth #(
  parameter int unsigned LEVELS  = 4,
  parameter int unsigned DEPTH_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic               pop_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               push_ok_o,
  output logic               underflow_o
);
  logic [DEPTH_W-1:0] depth_q;
  logic               pop_ok, uf_set;

  always_comb begin
    push_ok_o = push_i && (depth_q < DEPTH_W'(LEVELS));
    pop_ok    = pop_i && !push_i && (depth_q != '0);
    uf_set    = pop_i && !push_i && (depth_q == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q     <= '0;
      underflow_o <= 1'b0;
    end else begin
      underflow_o <= uf_set;
      if (push_ok_o)   depth_q <= depth_q + DEPTH_W'(1);
      else if (pop_ok) depth_q <= depth_q - DEPTH_W'(1);
    end
  end

  assign depth_o = depth_q;
endmodule

// File: rtl/retstack_dc_slots.sv
module retstack_dc_slots #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned SLOTS   = 3,
  parameter int unsigned DEPTH_W = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [DEPTH_W-1:0]           wr_lvl_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  output logic [SLOTS-1:0][ADDR_W-1:0] slots_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        slots_o[g] <= '0;
      else if (wr_en_i && (wr_lvl_i == DEPTH_W'(g)))
        slots_o[g] <= wr_addr_i;
    end
  end
endmodule

// File: rtl/retstack_dc_counter.sv
module retstack_dc_counter
  import retstack_dc_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned LO_W   = 4,
  parameter int unsigned MID_W  = 4,
  parameter int unsigned FLD_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ret_i,
  input  logic [ADDR_W-1:0] ret_addr_i,
  input  logic              ld_i,
  input  logic [1:0]        fld_i,
  input  logic [FLD_W-1:0]  ld_data_i,
  input  logic              inc_i,
  input  logic              hold_i,
  output logic [ADDR_W-1:0] dc_o
);
  localparam int unsigned HI_W = ADDR_W - LO_W - MID_W;

  logic [ADDR_W-1:0] dc_q, dc_d;

  // a return address written into the shared level beats any pointer update
  always_comb begin
    dc_d = dc_q;
    if (wr_ret_i) begin
      dc_d = ret_addr_i;
    end else if (ld_i) begin
      unique case (dc_fld_e'(fld_i))
        FLD_LO:  dc_d[LO_W-1:0]        = ld_data_i[LO_W-1:0];
        FLD_MID: dc_d[LO_W +: MID_W]   = ld_data_i[MID_W-1:0];
        FLD_HI:  dc_d[ADDR_W-1 -: HI_W] = ld_data_i[HI_W-1:0];
        default: dc_d = dc_q;
      endcase
    end else if (inc_i && !hold_i) begin
      dc_d = dc_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dc_q <= '0;
    else         dc_q <= dc_d;
  end

  assign dc_o = dc_q;
endmodule

// File: rtl/retstack_dc.sv
module retstack_dc
  import retstack_dc_pkg::*;
#(
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned LEVELS    = LEVELS_DEF,
  parameter int unsigned LO_W      = LO_W_DEF,
  parameter int unsigned MID_W     = MID_W_DEF,
  parameter int unsigned FLD_W     = FLD_W_DEF,
  parameter int unsigned ROM_WORDS = ROM_WORDS_DEF,
  localparam int unsigned DEPTH_W  = $clog2(LEVELS + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [ADDR_W-1:0]  push_addr_i,
  input  logic               pop_i,
  input  logic               dc_ld_i,
  input  logic [1:0]         dc_fld_i,
  input  logic [FLD_W-1:0]   dc_ld_data_i,
  input  logic               dc_inc_i,
  output logic [ADDR_W-1:0]  dc_o,
  output logic [ADDR_W-1:0]  top_o,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               underflow_o,
  output logic               dc_in_range_o
);
  localparam int unsigned SLOTS = LEVELS - 1;
  localparam logic [ADDR_W:0] ROM_LIM = (ADDR_W + 1)'(ROM_WORDS);

  logic                         push_ok, wr_ret;
  logic [SLOTS-1:0][ADDR_W-1:0] slots;

  retstack_dc_depth #(.LEVELS(LEVELS), .DEPTH_W(DEPTH_W)) u_depth (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .depth_o     (depth_o),
    .push_ok_o   (push_ok),
    .underflow_o (underflow_o)
  );

  retstack_dc_slots #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .DEPTH_W(DEPTH_W)) u_slots (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (push_ok),
    .wr_lvl_i  (depth_o),
    .wr_addr_i (push_addr_i),
    .slots_o   (slots)
  );

  assign wr_ret = push_ok && (depth_o == DEPTH_W'(SLOTS));

  retstack_dc_counter #(
    .ADDR_W(ADDR_W), .LO_W(LO_W), .MID_W(MID_W), .FLD_W(FLD_W)
  ) u_dc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ret_i   (wr_ret),
    .ret_addr_i (push_addr_i),
    .ld_i       (dc_ld_i),
    .fld_i      (dc_fld_i),
    .ld_data_i  (dc_ld_data_i),
    .inc_i      (dc_inc_i),
    .hold_i     (push_i || pop_i),
    .dc_o       (dc_o)
  );

  always_comb begin
    top_o = '0;
    if (depth_o == DEPTH_W'(LEVELS)) top_o = dc_o;
    for (int k = 0; k < SLOTS; k++)
      if (depth_o == DEPTH_W'(k + 1)) top_o = slots[k];
  end

  assign dc_in_range_o = ({1'b0, dc_o} < ROM_LIM);
endmodule

// File: rtl/retstack_dc_chk.sv
module retstack_dc_chk #(
  parameter int unsigned ADDR_W  = 11,
  parameter int unsigned LEVELS  = 4,
  parameter int unsigned DEPTH_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               push_i,
  input logic [ADDR_W-1:0]  push_addr_i,
  input logic               pop_i,
  input logic               dc_ld_i,
  input logic               dc_inc_i,
  input logic [ADDR_W-1:0]  dc_o,
  input logic [ADDR_W-1:0]  top_o,
  input logic [DEPTH_W-1:0] depth_o,
  input logic               underflow_o
);
  localparam logic [DEPTH_W-1:0] FULL = DEPTH_W'(LEVELS);
  localparam logic [DEPTH_W-1:0] LAST = DEPTH_W'(LEVELS - 1);

  a_r1_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= FULL);

  a_r2_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && depth_o < FULL) |=>
      (depth_o == $past(depth_o) + DEPTH_W'(1)) && (top_o == $past(push_addr_i)));

  a_r3_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && depth_o != '0) |=> depth_o == $past(depth_o) - DEPTH_W'(1));

  a_r4_level3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && depth_o == LAST) |=> dc_o == $past(push_addr_i));

  a_r7_inc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dc_inc_i && !dc_ld_i && (push_i || pop_i) && !(push_i && depth_o == LAST))
      |=> $stable(dc_o));

  a_r8_uf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && depth_o == '0) |=> underflow_o && depth_o == '0);

  a_r8_uf_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && !push_i && depth_o == '0) |=> !underflow_o);

  a_r9_full_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && depth_o == FULL) |=> depth_o == FULL);
endmodule

bind retstack_dc retstack_dc_chk #(
  .ADDR_W(ADDR_W), .LEVELS(LEVELS), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .push_addr_i (push_addr_i),
  .pop_i       (pop_i),
  .dc_ld_i     (dc_ld_i),
  .dc_inc_i    (dc_inc_i),
  .dc_o        (dc_o),
  .top_o       (top_o),
  .depth_o     (depth_o),
  .underflow_o (underflow_o)
);

// File: tb/retstack_dc_bench.sv
module retstack_dc_bench;
  localparam int CLK_P = 10;

  typedef struct {
    string       tag;
    logic [10:0] dc;
    logic [10:0] top;
    logic [2:0]  depth;
    logic        uf;
    logic        inr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0, ld = 1'b0, inc = 1'b0;
  logic [10:0] paddr = '0;
  logic [1:0]  fld = '0;
  logic [3:0]  ldat = '0;
  logic [10:0] dc_o, top_o;
  logic [2:0]  depth_o;
  logic        uf_o, inr_o;

  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  exp_t sb_q[$];

  // model state
  int          m_depth = 0;
  logic [10:0] m_stk [0:2];
  logic [10:0] m_dc = '0;
  logic        m_uf = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  retstack_dc u_retstack_dc (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_addr_i(paddr), .pop_i(pop),
    .dc_ld_i(ld), .dc_fld_i(fld), .dc_ld_data_i(ldat), .dc_inc_i(inc),
    .dc_o(dc_o), .top_o(top_o), .depth_o(depth_o), .underflow_o(uf_o),
    .dc_in_range_o(inr_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [10:0] m_top();
    if (m_depth == 0) return '0;
    if (m_depth == 4) return m_dc;
    return m_stk[m_depth-1];
  endfunction

  task automatic step(string tag, bit p, logic [10:0] a, bit q, bit l,
                      logic [1:0] f, logic [3:0] d, bit i);
    exp_t e;
    int   d0;
    @(negedge clk);
    push = p; paddr = a; pop = q; ld = l; fld = f; ldat = d; inc = i;
    d0   = m_depth;
    m_uf = q && !p && d0 == 0;
    if (p && d0 < 4) begin
      if (d0 == 3) m_dc = a; else m_stk[d0] = a;
      m_depth++;
    end else if (q && !p && d0 > 0) begin
      m_depth--;
    end
    if (!(p && d0 == 3)) begin
      if (l) begin
        case (f)
          2'd0: m_dc[3:0]  = d;
          2'd1: m_dc[7:4]  = d;
          2'd2: m_dc[10:8] = d[2:0];
          default: ;
        endcase
      end else if (i && !p && !q) begin
        m_dc = m_dc + 11'd1;
      end
    end
    e.tag = tag; e.dc = m_dc; e.top = m_top(); e.depth = 3'(m_depth);
    e.uf = m_uf; e.inr = (m_dc < 11'd1024);
    sb_q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(tag, 0, '0, 0, 0, 2'd0, 4'd0, 0);
  endtask

  // monitor: results due one edge after the request
  always @(posedge clk) begin
    exp_t e;
    #(CLK_P/4);
    if (rst_n && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk(e.tag, "dc_o", 32'(dc_o), 32'(e.dc));
      chk(e.tag, "top_o", 32'(top_o), 32'(e.top));
      chk(e.tag, "depth_o", 32'(depth_o), 32'(e.depth));
      chk(e.tag, "underflow_o", 32'(uf_o), 32'(e.uf));
      chk(e.tag, "dc_in_range_o", 32'(inr_o), 32'(e.inr));
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) m_stk[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "depth_o", 32'(depth_o), 0);
    chk("R1", "dc_o", 32'(dc_o), 0);
    chk("R1", "top_o", 32'(top_o), 0);
    chk("R1", "underflow_o", 32'(uf_o), 0);
    idle("R1 idle");
    // field loads
    step("R6 low", 0, '0, 0, 1, 2'd0, 4'h5, 0);
    step("R6 mid", 0, '0, 0, 1, 2'd1, 4'hA, 0);
    step("R6 hi", 0, '0, 0, 1, 2'd2, 4'h3, 0);
    step("R6 code3 none", 0, '0, 0, 1, 2'd3, 4'hF, 0);
    step("R10 bit10 set", 0, '0, 0, 1, 2'd2, 4'h4, 0);
    step("R10 back low", 0, '0, 0, 1, 2'd2, 4'h3, 0);
    // wrap
    step("R7 lo F", 0, '0, 0, 1, 2'd0, 4'hF, 0);
    step("R7 mid F", 0, '0, 0, 1, 2'd1, 4'hF, 0);
    step("R7 hi 7", 0, '0, 0, 1, 2'd2, 4'h7, 0);
    step("R7 wrap", 0, '0, 0, 0, 2'd0, 4'h0, 1);
    step("R7 inc", 0, '0, 0, 0, 2'd0, 4'h0, 1);
    step("R7 R8 inc with pop empty", 0, '0, 1, 0, 2'd0, 4'h0, 1);
    idle("R8 pulse ends");
    step("R7 load beats inc", 0, '0, 0, 1, 2'd0, 4'h9, 1);
    // pushes
    step("R2 push1", 1, 11'h100, 0, 0, 2'd0, 4'h0, 0);
    step("R2 push2", 1, 11'h200, 0, 0, 2'd0, 4'h0, 1);
    step("R2 push3", 1, 11'h300, 0, 0, 2'd0, 4'h0, 0);
    step("R4 push into dc", 1, 11'h345, 0, 0, 2'd0, 4'h0, 0);
    step("R9 push full", 1, 11'h7AA, 0, 0, 2'd0, 4'h0, 0);
    step("R5 inc at depth4", 0, '0, 0, 0, 2'd0, 4'h0, 1);
    step("R5 load at depth4", 0, '0, 0, 1, 2'd0, 4'h0, 0);
    step("R3 R5 pop corrupted", 0, '0, 1, 0, 2'd0, 4'h0, 0);
    step("R3 pop", 0, '0, 1, 0, 2'd0, 4'h0, 0);
    step("R9 push and pop", 1, 11'h055, 1, 0, 2'd0, 4'h0, 0);
    step("R11 push beats load", 1, 11'h6EE, 0, 1, 2'd1, 4'h1, 0);
    step("R3 pop a", 0, '0, 1, 0, 2'd0, 4'h0, 0);
    step("R3 pop b", 0, '0, 1, 0, 2'd0, 4'h0, 0);
    step("R3 pop c", 0, '0, 1, 0, 2'd0, 4'h0, 0);
    step("R3 pop d", 0, '0, 1, 0, 2'd0, 4'h0, 0);
    step("R8 pop empty", 0, '0, 1, 0, 2'd0, 4'h0, 0);
    idle("R8 clear");
    idle("R1 drain");
    repeat (3) @(posedge clk);
    #(CLK_P/2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule